// File: doc/BRIEF.md
# Sliced VBI Nibble Output Formatter

This block sits between a teletext-style data slicer and a dual 8-bit video output made of a luma port and a chroma port. On lines that fall inside the vertical blanking window, it replaces the video samples with a fixed-length packet of slicer bytes. Any slot that the slicer leaves empty is filled with a programmable pad byte. Outside the window, and in slots past the end of the packet, the normal luma and chroma inputs pass straight through.

In the default split mode, each packet byte is cut into two nibbles. The high nibble goes to the chroma port and the low nibble goes to the luma port. Each nibble is written twice to fill the byte, and bit 0 of the result is inverted. Because of this, the sync-reserved codes 0x00 and 0xFF can never appear on either port. When embedded timing codes are in use, the chroma byte is narrowed further by forcing only its two lowest bits. A split-disable control sends each raw byte on luma only. In that mode the luma port has an optional 0x01..0xFE clamp.

Slots are counted while the active-video flag is high, and the count restarts when the flag rises. The current slot index is presented to the slicer in the same cycle, so that the slicer can supply the matching byte. Every port result is registered once.

Top module: `vbi_nibble_fmt`

## Requirements
- R1: While rst_n is low at a clock edge, out_y and out_c become 0x00, and byte_idx reads 0 on the following cycle when vid_active is low.
- R2: When a slot is not a packet slot, out_y and out_c equal vid_y and vid_c one clock later. A packet slot is one where vbi_line=1, vid_active=1 and byte_idx < the effective length.
- R3: In split mode (split_dis=0) with tcode_en=0, a packet slot carrying byte b gives, one clock later, out_c = {b[7:4], b[7:5], ~b[4]} and out_y = {b[3:0], b[3:1], ~b[0]}.
- R4: byte_idx is 0 in the first cycle after vid_active rises (low the cycle before, including reset). It increases by one in each further cycle that vid_active is high, and saturates at MAX_LEN. It holds while vid_active is low. Byte D(k+1) of a packet is the one taken in the slot where byte_idx = k.
- R5: The effective packet length is pkt_len, limited to MAX_LEN (64). Slots with byte_idx at or above this length are not packet slots. pkt_len = 0 gives no packet slots.
- R6: In a packet slot where slc_valid=0, the byte sent is pad_byte instead of slc_byte, and it is encoded in the same way.
- R7: In split mode, neither port ever outputs 0x00 or 0xFF for a packet slot.
- R8: With tcode_en=1 in split mode, the chroma code is limited by changing bits 1..0 only. When bits 7..2 are all zero, bits 1..0 become 11. When bits 7..2 are all one, bits 1..0 become 00. The chroma result therefore lies in 0x03..0xFC.
- R9: With split_dis=1 and luma_lim_off=0, a packet slot gives out_c = 0x80. It also gives out_y = b, except that 0x00 becomes 0x01 and 0xFF becomes 0xFE.
- R10: With split_dis=1 and luma_lim_off=1, out_y = b unmodified (0x00 and 0xFF included) and out_c = 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vid_active | input | 1 | Active-video flag; one slot per high cycle |
| vbi_line | input | 1 | Current line lies inside the VBI window |
| split_dis | input | 1 | 1: raw bytes on luma only |
| luma_lim_off | input | 1 | 1: no luma clamp in split-disable mode |
| tcode_en | input | 1 | Embedded timing codes on: extra chroma limiting |
| pkt_len | input | 7 | Packet length in bytes (64 by default, above 64 limited) |
| pad_byte | input | 8 | Dummy byte for empty slots (0x00 by default) |
| slc_valid | input | 1 | Slicer supplies a byte in this slot |
| slc_byte | input | 8 | Slicer byte for slot byte_idx |
| vid_y | input | 8 | Normal luma video |
| vid_c | input | 8 | Normal chroma video |
| byte_idx | output | 7 | Slot index of the current cycle |
| out_y | output | 8 | Luma port |
| out_c | output | 8 | Chroma port |

## Verification
byte_idx is combinational from the current vid_active and the slot counter. It is therefore checked in the same cycle as the stimulus, 1 ns after the inputs are driven on the falling edge. out_y and out_c pass through one output register. Each of them is checked 1 ns after the rising edge that follows the inputs, and is compared with a value that the bench computes from the inputs of that single cycle. The bench keeps its own slot count, updated at each modelled edge. This keeps the packet boundary, the restart on the rising edge of vid_active and the length limit aligned with the one-cycle port latency.

// File: rtl/vbi_fmt_pkg.sv
// Shared constants and coding helpers for the sliced VBI formatter.
// Assumes 8-bit samples; the nibble split is defined only for 8 bits.
package vbi_fmt_pkg;

    localparam logic [7:0] CHROMA_NEUTRAL = 8'h80;

    // Repeat a nibble to fill a byte and invert bit 0 (odd parity).
    function automatic logic [7:0] dup_nibble(input logic [3:0] n);
        return {n, n[3:1], ~n[0]};
    endfunction

    // Chroma limit for timing-code mode: touches bits 1..0 only.
    function automatic logic [7:0] tc_limit(input logic [7:0] v);
        logic [7:0] r;
        r = v;
        if (v[7:2] == 6'h00)      r[1:0] = 2'b11;
        else if (v[7:2] == 6'h3F) r[1:0] = 2'b00;
        return r;
    endfunction

    // Keep a raw luma byte off the two reserved sync codes.
    function automatic logic [7:0] luma_clamp(input logic [7:0] v);
        logic [7:0] r;
        r = v;
        if (v == 8'h00)      r = 8'h01;
        else if (v == 8'hFF) r = 8'hFE;
        return r;
    endfunction

endpackage

// File: rtl/vbi_slot_counter.sv
// Slot counter: numbers the active-video cycles of a line.
// Restarts at 0 on the rising edge of the active flag, which is seen
// combinationally in the same cycle. Saturates at MAX_LEN and holds
// while the flag is low.
module vbi_slot_counter #(
    parameter int MAX_LEN = 64,
    localparam int IW = $clog2(MAX_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    output logic [IW-1:0] slot_idx
);
    localparam logic [IW-1:0] LIMIT = IW'(MAX_LEN);

    logic          act_q;
    logic [IW-1:0] cnt_q;

    // Current slot index: zero on the first active cycle.
    always_comb slot_idx = (active && !act_q) ? '0 : cnt_q;

    // Advance the count and remember the previous flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            act_q <= active;
            if (active)
                cnt_q <= (slot_idx == LIMIT) ? LIMIT : slot_idx + 1'b1;
        end
    end

    // R4
    property p_restart;
        @(posedge clk) disable iff (!rst_n)
        (active && !act_q) |=> (!active || slot_idx == IW'(1));
    endproperty
    restart_chk: assert property (p_restart);

    // R4
    property p_step;
        @(posedge clk) disable iff (!rst_n)
        (active && act_q && slot_idx < LIMIT) |=>
            (!active || slot_idx == $past(slot_idx) + 1'b1);
    endproperty
    step_chk: assert property (p_step);

endmodule

// File: rtl/vbi_nibble_enc.sv
// Byte encoder for one packet slot. Split mode: nibbles are duplicated
// with bit 0 inverted, high nibble to chroma and low nibble to luma,
// plus an optional chroma limit for timing-code mode. Split-disable
// mode: raw byte on luma with an optional clamp, neutral chroma.
// Purely combinational.
module vbi_nibble_enc
    import vbi_fmt_pkg::*;
(
    input  logic [7:0] din,
    input  logic       split_dis,
    input  logic       luma_lim_off,
    input  logic       tcode_en,
    output logic [7:0] enc_y,
    output logic [7:0] enc_c
);
    logic [7:0] c_dup;

    // Encode one byte for the selected mode.
    always_comb begin
        c_dup = dup_nibble(din[7:4]);
        if (split_dis) begin
            enc_y = luma_lim_off ? din : luma_clamp(din);
            enc_c = CHROMA_NEUTRAL;
        end else begin
            enc_y = dup_nibble(din[3:0]);
            enc_c = tcode_en ? tc_limit(c_dup) : c_dup;
        end
    end
endmodule

// File: rtl/vbi_nibble_fmt.sv
// Top of the sliced VBI formatter. Decides for each cycle whether the
// slot belongs to the packet (inside the window, active, index below
// the effective length). For a packet slot it sends the encoded slicer
// or pad byte; otherwise it passes the video through. One output
// register; byte_idx is combinational for the slicer.
module vbi_nibble_fmt
    import vbi_fmt_pkg::*;
#(
    parameter int MAX_LEN = 64,
    localparam int IW = $clog2(MAX_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vid_active,
    input  logic          vbi_line,
    input  logic          split_dis,
    input  logic          luma_lim_off,
    input  logic          tcode_en,
    input  logic [IW-1:0] pkt_len,
    input  logic [7:0]    pad_byte,
    input  logic          slc_valid,
    input  logic [7:0]    slc_byte,
    input  logic [7:0]    vid_y,
    input  logic [7:0]    vid_c,
    output logic [IW-1:0] byte_idx,
    output logic [7:0]    out_y,
    output logic [7:0]    out_c
);
    localparam logic [IW-1:0] LIMIT = IW'(MAX_LEN);

    logic [IW-1:0] len_eff;
    logic          in_pkt;
    logic [7:0]    pkt_byte;
    logic [7:0]    enc_y, enc_c;
    logic          pkt_q, split_q, tc_q;

    vbi_slot_counter #(.MAX_LEN(MAX_LEN)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (vid_active),
        .slot_idx (byte_idx)
    );

    // Limit the programmed length and select the byte for this slot.
    always_comb begin
        len_eff  = (pkt_len > LIMIT) ? LIMIT : pkt_len;
        in_pkt   = vbi_line && vid_active && (byte_idx < len_eff);
        pkt_byte = slc_valid ? slc_byte : pad_byte;
    end

    vbi_nibble_enc u_enc (
        .din          (pkt_byte),
        .split_dis    (split_dis),
        .luma_lim_off (luma_lim_off),
        .tcode_en     (tcode_en),
        .enc_y        (enc_y),
        .enc_c        (enc_c)
    );

    // Output register: encoded packet byte or video pass-through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_y   <= 8'h00;
            out_c   <= 8'h00;
            pkt_q   <= 1'b0;
            split_q <= 1'b0;
            tc_q    <= 1'b0;
        end else begin
            out_y   <= in_pkt ? enc_y : vid_y;
            out_c   <= in_pkt ? enc_c : vid_c;
            pkt_q   <= in_pkt;
            split_q <= split_dis;
            tc_q    <= tcode_en;
        end
    end

    // R7
    property p_no_reserved;
        @(posedge clk) disable iff (!rst_n)
        (pkt_q && !split_q) |->
            (out_y != 8'h00 && out_y != 8'hFF && out_c != 8'h00 && out_c != 8'hFF);
    endproperty
    no_reserved_chk: assert property (p_no_reserved);

    // R8
    property p_chroma_range;
        @(posedge clk) disable iff (!rst_n)
        (pkt_q && !split_q && tc_q) |-> (out_c >= 8'h03 && out_c <= 8'hFC);
    endproperty
    chroma_range_chk: assert property (p_chroma_range);

    // R2
    property p_passthru;
        @(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !pkt_q) |-> (out_y == $past(vid_y) && out_c == $past(vid_c));
    endproperty
    passthru_chk: assert property (p_passthru);

    // R9
    property p_split_chroma;
        @(posedge clk) disable iff (!rst_n)
        (pkt_q && split_q) |-> (out_c == CHROMA_NEUTRAL);
    endproperty
    split_chroma_chk: assert property (p_split_chroma);

endmodule

// File: tb/tb_vbi_nibble_fmt.sv
module tb_vbi_nibble_fmt;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vid_active = 0, vbi_line = 0, split_dis = 0, luma_lim_off = 0, tcode_en = 0;
    logic [6:0] pkt_len = 7'd64;
    logic [7:0] pad_byte = 8'h00;
    logic       slc_valid = 0;
    logic [7:0] slc_byte = 0, vid_y = 0, vid_c = 0;
    logic [6:0] byte_idx;
    logic [7:0] out_y, out_c;

    int n_cmp = 0;
    int n_bad = 0;
    int m_cnt = 0;
    bit m_prev = 0;

    always #10 clk = ~clk;   // 50 MHz

    vbi_nibble_fmt dut (
        .clk(clk), .rst_n(rst_n), .vid_active(vid_active), .vbi_line(vbi_line),
        .split_dis(split_dis), .luma_lim_off(luma_lim_off), .tcode_en(tcode_en),
        .pkt_len(pkt_len), .pad_byte(pad_byte), .slc_valid(slc_valid),
        .slc_byte(slc_byte), .vid_y(vid_y), .vid_c(vid_c),
        .byte_idx(byte_idx), .out_y(out_y), .out_c(out_c)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dup_ref(input logic [3:0] n);
        logic [7:0] v;
        v = {n, n};
        v = v ^ 8'h01;
        return v;
    endfunction

    // One slot: drive at falling edge, check index, then outputs after the edge.
    task automatic step(input bit act, input bit win, input bit vld,
                        input logic [7:0] sb, input logic [7:0] vy, input logic [7:0] vc);
        int idx, len;
        bit inpkt;
        logic [7:0] b, ey, ec;
        string tag;
        @(negedge clk);
        vid_active = act; vbi_line = win; slc_valid = vld;
        slc_byte = sb; vid_y = vy; vid_c = vc;
        #1;
        idx = (act && !m_prev) ? 0 : m_cnt;
        chk(int'(byte_idx) == idx, "R4", int'(byte_idx), idx);
        len = (int'(pkt_len) > 64) ? 64 : int'(pkt_len);
        inpkt = win && act && (idx < len);
        b = vld ? sb : pad_byte;
        if (!inpkt) begin
            ey = vy; ec = vc;
            tag = (win && act) ? "R5" : "R2";
        end else if (split_dis) begin
            ey = b; ec = 8'h80;
            if (!luma_lim_off) begin
                if (b == 8'h00) ey = 8'h01;
                if (b == 8'hFF) ey = 8'hFE;
                tag = "R9";
            end else tag = "R10";
        end else begin
            ey = dup_ref(b[3:0]);
            ec = dup_ref(b[7:4]);
            if (tcode_en) begin
                if (ec < 8'h03) ec = 8'h03;
                if (ec > 8'hFC) ec = 8'hFC;
                tag = "R8";
            end else tag = vld ? "R3" : "R6";
        end
        if (act) m_cnt = (idx + 1 > 64) ? 64 : idx + 1;
        m_prev = act;
        @(posedge clk);
        #1;
        chk(out_y == ey, tag, out_y, ey);
        chk(out_c == ec, tag, out_c, ec);
        if (inpkt && !split_dis)
            chk(out_y != 8'h00 && out_y != 8'hFF && out_c != 8'h00 && out_c != 8'hFF,
                "R7", {out_c, out_y}, 0);
    endtask

    task automatic cfg(input bit sd, input bit lo, input bit tc, input int len, input logic [7:0] pad);
        split_dis = sd; luma_lim_off = lo; tcode_en = tc; pkt_len = 7'(len); pad_byte = pad;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        vid_y = 8'h5A; vid_c = 8'hA5;
        repeat (3) @(posedge clk);
        #1;
        chk(out_y == 8'h00, "R1", out_y, 0);
        chk(out_c == 8'h00, "R1", out_c, 0);
        chk(byte_idx == 7'd0, "R1", byte_idx, 0);
        @(negedge clk); rst_n = 1'b1;
        m_cnt = 0; m_prev = 0;

        // Full line, default length 64, slots past the end pass through (R5)
        cfg(0, 0, 0, 64, 8'h00);
        for (int k = 0; k < 70; k++) step(1, 1, 1, 8'(k * 37 + 5), 8'(k), 8'(~k));
        for (int k = 0; k < 3; k++) step(0, 1, 1, 8'h11, 8'h40, 8'h41);
        // Reserved-code extremes, plain and with timing-code limit
        step(1, 1, 1, 8'h00, 8'h10, 8'h20);
        step(1, 1, 1, 8'hFF, 8'h10, 8'h20);
        cfg(0, 0, 1, 64, 8'h00);
        step(1, 1, 1, 8'h00, 8'h10, 8'h20);
        step(1, 1, 1, 8'hFF, 8'h10, 8'h20);
        step(1, 1, 1, 8'h0F, 8'h10, 8'h20);
        step(1, 1, 1, 8'hF0, 8'h10, 8'h20);
        // Padding (R6)
        cfg(0, 0, 0, 64, 8'hC3);
        step(1, 1, 0, 8'h77, 8'h10, 8'h20);
        cfg(0, 0, 0, 64, 8'h00);
        step(1, 1, 0, 8'h77, 8'h10, 8'h20);
        // Split disable with and without clamp (R9, R10)
        cfg(1, 0, 0, 64, 8'h00);
        step(1, 1, 1, 8'h00, 8'h10, 8'h20);
        step(1, 1, 1, 8'hFF, 8'h10, 8'h20);
        step(1, 1, 1, 8'h6B, 8'h10, 8'h20);
        cfg(1, 1, 0, 64, 8'h00);
        step(1, 1, 1, 8'h00, 8'h10, 8'h20);
        step(1, 1, 1, 8'hFF, 8'h10, 8'h20);
        step(0, 0, 0, 8'h00, 8'h10, 8'h20);
        // Length above the limit, then zero length (R5)
        cfg(0, 0, 0, 100, 8'h00);
        for (int k = 0; k < 67; k++) step(1, 1, 1, 8'(k + 1), 8'h33, 8'h44);
        step(0, 1, 1, 8'h00, 8'h33, 8'h44);
        cfg(0, 0, 0, 0, 8'h00);
        for (int k = 0; k < 5; k++) step(1, 1, 1, 8'h99, 8'h55, 8'h66);
        step(0, 1, 1, 8'h00, 8'h33, 8'h44);
        // Short packet
        cfg(0, 0, 0, 3, 8'h00);
        for (int k = 0; k < 6; k++) step(1, 1, 1, 8'hA0 + 8'(k), 8'h55, 8'h66);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            if (i % 150 == 0)
                cfg($urandom % 4 == 0, $urandom % 2, $urandom % 2,
                    ($urandom % 3 == 0) ? ($urandom % 128) : 64, 8'($urandom));
            step($urandom % 8 != 0, $urandom % 4 != 0, $urandom % 5 != 0,
                 8'($urandom), 8'($urandom), 8'($urandom));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule